// File: doc/BRIEF.md
# BCD Clock-Calendar Counter

This block keeps time of day and date as packed BCD digits: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A free-running prescaler counts pulses of a 32.768 kHz enable and produces one second carry each time it wraps. The carry moves through the fields, and the calendar applies Gregorian month lengths with leap Februaries. The host reads and writes single 4-bit digits by address. Hours can be shown in 24-hour form or in a 12-hour form that uses a PM bit.

A `run` input acts as a write-protect gate for counting. While it is low, the counters stay frozen so the host can read or write a consistent time. A second that arrives in this window is remembered and is applied exactly once when `run` returns high. An adjust request rounds the time to the nearest minute. A `busy` flag stays high for a fixed number of 32 kHz enables after every counter update.

Top module: `bcd_rtc_core`

## Requirements
- R1: Seconds and minutes count BCD 00..59. Going from 59 to 00 carries into the next field. The tens digits of both fields are 3 bits wide, and the top bit reads 0.
- R2: With `mode24`=1, hours run from 00 to 23. Going from 23 to 00 advances the date.
- R3: With `mode24`=0, bit 1 of the hour-tens digit is PM. The sequence is 12(AM), 01..11, 32(PM12), 21..31, then back to 12. Only the step from 31 to 12 advances the date.
- R4: Day of week counts 0..6 and wraps to 0 on each date advance. A written 7 becomes 0 on the next advance.
- R5: Day of month wraps to 01 after the month's last day. April, June, September and November have 30 days. February has 29 days when the BCD year is a multiple of 4 (00 included) and 28 days otherwise. All other months have 31 days.
- R6: Month wraps from 12 to 01 and carries into the year. The year wraps from 99 to 00.
- R7: While `run`=0, second carries change no field. When `run` returns to 1, the seconds advance by exactly one, however many carries arrived.
- R8: An adjust request sets seconds to 00 and clears the prescaler. It also increments the minutes (with full carry) when seconds were 30..59.
- R9: An adjust request made while `run`=0 waits until `run`=1. An adjust and a carry that fall in the same cycle apply only the adjust, and the carry is discarded.
- R10: `busy` rises on the cycle after a carry or adjust is applied. It stays high for exactly 3 `tick32k` pulses after a carry and 4 after an adjust.
- R11: A write replaces the addressed digit. A write in the cycle of a carry defers the carry by one clock. Out-of-range values are not corrected, but they still wrap to the field's base value on the next advance.
- R12: The digit addresses are 0 s-ones, 1 s-tens, 2 m-ones, 3 m-tens, 4 h-ones, 5 h-tens, 6 weekday, 7 d-ones, 8 d-tens, 9 mo-ones, 10 mo-tens, 11 y-ones and 12 y-tens. Addresses 13..15 read 0. After reset the time is 00:00:00 on 01/01/00, weekday is 0 and `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick32k | input | 1 | One-cycle enable at 32.768 kHz |
| mode24 | input | 1 | 1 selects 24-hour hours, 0 selects 12-hour with PM bit |
| run | input | 1 | 1 lets second carries advance the counters |
| adj_req | input | 1 | One-cycle request to round to the nearest minute |
| wr | input | 1 | Digit write strobe |
| addr | input | 4 | Digit address |
| wdata | input | 4 | Digit write value |
| rdata | output | 4 | Digit at `addr`, unused bits zero |
| busy | output | 1 | Counter update in progress |

## Verification
A pending adjust and a held second carry can both fall due in the same cycle, the one where `run` returns high. The bench provokes this by holding `run` low, issuing an adjust at second 45 and letting a full second pass. It then raises `run` and requires seconds 00 with minutes plus one. It also requires that seconds stay at 00 afterwards, which shows the coincident carry was discarded and not just deferred. A write that lands on the prescaler wrap is judged the same way: the written digit must stick, and the seconds must advance once on the following clock.

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core #(
  parameter int PRE_W       = 15,
  parameter int CARRY_TICKS = 3,
  parameter int ADJ_TICKS   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick32k,
  input  logic       mode24,
  input  logic       run,
  input  logic       adj_req,
  input  logic       wr,
  input  logic [3:0] addr,
  input  logic [3:0] wdata,
  output logic [3:0] rdata,
  output logic       busy
);
  localparam int BW = $clog2(ADJ_TICKS + 1);

  logic [PRE_W-1:0] pre;
  logic [6:0] sec, min;
  logic [5:0] hr, day, mlen, hr_nx;
  logic [4:0] mon;
  logic [2:0] dow;
  logic [7:0] yr;
  logic       pend, adj_pend, dc;
  logic [BW-1:0] bcnt;

  function automatic logic [7:0] inc_bcd(input logic [7:0] v);
    inc_bcd = (v[3:0] >= 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  wire sec_evt  = tick32k && (&pre);
  wire adj_go   = adj_pend && run && !wr;
  wire inc_go   = (pend || sec_evt) && run && !wr && !adj_go;
  wire sec_wrap = sec >= 7'h59;
  wire min_step = inc_go ? sec_wrap : (adj_go && sec >= 7'h30);
  wire hr_step  = min_step && (min >= 7'h59);
  wire day_step = hr_step && dc;
  wire leap     = yr[4] ? (yr[3:0] == 4'd2 || yr[3:0] == 4'd6)
                        : (yr[3:0] == 4'd0 || yr[3:0] == 4'd4 || yr[3:0] == 4'd8);
  wire mon_step = day_step && (day >= mlen);
  wire yr_step  = mon_step && (mon >= 5'h12);

  assign busy = bcnt != '0;

  always_comb begin
    dc = 1'b0;
    if (mode24) begin
      if (hr >= 6'h23) begin hr_nx = 6'h00; dc = 1'b1; end
      else hr_nx = 6'(inc_bcd({2'b0, hr}));
    end else if (hr[4:0] == 5'h12) hr_nx = {hr[5], 5'h01};
    else if (hr[4:0] >= 5'h11) begin hr_nx = {~hr[5], 5'h12}; dc = hr[5]; end
    else hr_nx = {hr[5], 5'(inc_bcd({3'b0, hr[4:0]}))};
  end

  always_comb
    case (mon)
      5'h02:                      mlen = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: mlen = 6'h30;
      default:                    mlen = 6'h31;
    endcase

  always_comb
    case (addr)
      4'd0:    rdata = sec[3:0];
      4'd1:    rdata = {1'b0, sec[6:4]};
      4'd2:    rdata = min[3:0];
      4'd3:    rdata = {1'b0, min[6:4]};
      4'd4:    rdata = hr[3:0];
      4'd5:    rdata = {2'b0, hr[5:4]};
      4'd6:    rdata = {1'b0, dow};
      4'd7:    rdata = day[3:0];
      4'd8:    rdata = {2'b0, day[5:4]};
      4'd9:    rdata = mon[3:0];
      4'd10:   rdata = {3'b0, mon[4]};
      4'd11:   rdata = yr[3:0];
      4'd12:   rdata = yr[7:4];
      default: rdata = 4'd0;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre <= '0; pend <= 1'b0; adj_pend <= 1'b0; bcnt <= '0;
      sec <= '0; min <= '0; hr <= '0; dow <= '0;
      day <= 6'h01; mon <= 5'h01; yr <= '0;
    end else begin
      if (adj_go) pre <= '0;
      else if (tick32k) pre <= pre + 1'b1;
      pend     <= (pend || sec_evt) && !inc_go && !adj_go;
      adj_pend <= (adj_pend || adj_req) && !adj_go;
      if (adj_go) bcnt <= BW'(ADJ_TICKS);
      else if (inc_go) bcnt <= BW'(CARRY_TICKS);
      else if (tick32k && bcnt != '0) bcnt <= bcnt - 1'b1;
      if (wr)
        case (addr)
          4'd0:  sec[3:0] <= wdata;
          4'd1:  sec[6:4] <= wdata[2:0];
          4'd2:  min[3:0] <= wdata;
          4'd3:  min[6:4] <= wdata[2:0];
          4'd4:  hr[3:0]  <= wdata;
          4'd5:  hr[5:4]  <= wdata[1:0];
          4'd6:  dow      <= wdata[2:0];
          4'd7:  day[3:0] <= wdata;
          4'd8:  day[5:4] <= wdata[1:0];
          4'd9:  mon[3:0] <= wdata;
          4'd10: mon[4]   <= wdata[0];
          4'd11: yr[3:0]  <= wdata;
          4'd12: yr[7:4]  <= wdata;
          default: ;
        endcase
      else begin
        if (adj_go) sec <= '0;
        else if (inc_go) sec <= sec_wrap ? 7'h00 : 7'(inc_bcd({1'b0, sec}));
        if (min_step) min <= (min >= 7'h59) ? 7'h00 : 7'(inc_bcd({1'b0, min}));
        if (hr_step) hr <= hr_nx;
        if (day_step) begin
          dow <= (dow >= 3'd6) ? 3'd0 : dow + 3'd1;
          day <= (day >= mlen) ? 6'h01 : 6'(inc_bcd({2'b0, day}));
        end
        if (mon_step) mon <= (mon >= 5'h12) ? 5'h01 : 5'(inc_bcd({3'b0, mon}));
        if (yr_step) yr <= (yr >= 8'h99) ? 8'h00 : inc_bcd(yr);
      end
    end

  a_r1_sec_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && sec <= 7'h59 && sec[3:0] <= 4'd9) |=> (sec <= 7'h59 && sec[3:0] <= 4'd9));
  a_r4_dow_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && dow != 3'd7) |=> dow != 3'd7);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr) |=> $stable(sec) && $stable(min));
  a_r7_single: assert property (@(posedge clk) disable iff (!rst_n)
    inc_go |=> !pend);
  a_r8_adjust_zero: assert property (@(posedge clk) disable iff (!rst_n)
    adj_go |=> (sec == 7'h00 && pre == '0));
  a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_go || adj_go) |=> busy);
endmodule

// File: tb/bcd_rtc_core_test.sv
module bcd_rtc_core_test;
  logic clk = 0, rst_n = 0, tick32k = 0, mode24 = 1, run = 1, adj_req = 0, wr = 0;
  logic [3:0] drv_addr = 0, mon_addr = 0, wdata = 0, rdata;
  logic busy, mon_active = 0;
  wire [3:0] addr = mon_active ? mon_addr : drv_addr;

  typedef struct { logic [3:0] a; logic [3:0] v; string tag; } item_t;
  item_t q[$];
  int checks = 0, fails = 0, pushed = 0, served = 0, tcount = 0;

  always #4 clk = ~clk;

  bcd_rtc_core #(.PRE_W(4)) uut (.clk(clk), .rst_n(rst_n), .tick32k(tick32k), .mode24(mode24),
    .run(run), .adj_req(adj_req), .wr(wr), .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy));

  initial forever begin
    item_t it;
    wait (q.size() != 0);
    it = q.pop_front();
    @(negedge clk); mon_active = 1; mon_addr = it.a; #1;
    checks++;
    if (rdata !== it.v) begin
      fails++;
      $display("FAIL %s addr %0d: got %h expected %h", it.tag, it.a, rdata, it.v);
    end
    mon_active = 0; served++;
  end

  task automatic expect_dig(input logic [3:0] a, input logic [3:0] v, input string tag);
    item_t it;
    it.a = a; it.v = v; it.tag = tag;
    q.push_back(it); pushed++;
    wait (served == pushed);
  endtask

  task automatic chk_busy(input logic exp, input string tag);
    checks++;
    if (busy !== exp) begin
      fails++;
      $display("FAIL %s busy: got %b expected %b", tag, busy, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) tick32k = 1;
    @(negedge clk) tick32k = 0;
    tcount = (tcount + 1) % 16;
  endtask

  task automatic to_second();
    tick();
    while (tcount != 0) tick();
  endtask

  task automatic wr_dig(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk); drv_addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wr_dig(5, h[7:4]); wr_dig(4, h[3:0]); wr_dig(3, m[7:4]);
    wr_dig(2, m[3:0]); wr_dig(1, s[7:4]); wr_dig(0, s[3:0]);
  endtask

  task automatic set_date(input logic [7:0] d, input logic [7:0] mo, input logic [7:0] y);
    wr_dig(8, d[7:4]); wr_dig(7, d[3:0]); wr_dig(10, mo[7:4]);
    wr_dig(9, mo[3:0]); wr_dig(12, y[7:4]); wr_dig(11, y[3:0]);
  endtask

  task automatic exp_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s, input string tag);
    expect_dig(5, h[7:4], tag); expect_dig(4, h[3:0], tag); expect_dig(3, m[7:4], tag);
    expect_dig(2, m[3:0], tag); expect_dig(1, s[7:4], tag); expect_dig(0, s[3:0], tag);
  endtask

  task automatic exp_date(input logic [7:0] d, input logic [7:0] mo, input logic [7:0] y, input string tag);
    expect_dig(8, d[7:4], tag); expect_dig(7, d[3:0], tag); expect_dig(10, mo[7:4], tag);
    expect_dig(9, mo[3:0], tag); expect_dig(12, y[7:4], tag); expect_dig(11, y[3:0], tag);
  endtask

  task automatic adjust();
    @(negedge clk) adj_req = 1;
    @(negedge clk) adj_req = 0;
    @(negedge clk);
  endtask

  task automatic roll_date(input logic [7:0] d, input logic [7:0] mo, input logic [7:0] y,
                           input logic [7:0] ed, input logic [7:0] emo, input logic [7:0] ey, input string tag);
    set_date(d, mo, y); set_time(8'h23, 8'h59, 8'h59); to_second();
    exp_date(ed, emo, ey, tag);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    exp_time(8'h00, 8'h00, 8'h00, "R12 reset time");
    exp_date(8'h01, 8'h01, 8'h00, "R12 reset date");
    expect_dig(6, 0, "R12 reset weekday");
    expect_dig(13, 0, "R12 unused address");
    expect_dig(15, 0, "R12 unused address");
    chk_busy(0, "R12 reset busy");

    set_date(8'h15, 8'h06, 8'h21); wr_dig(6, 5);
    set_time(8'h23, 8'h59, 8'h59); to_second();
    chk_busy(1, "R10 busy after carry");
    tick(); tick(); chk_busy(1, "R10 busy held 2 ticks");
    tick(); chk_busy(0, "R10 busy ends after 3 ticks");
    exp_time(8'h00, 8'h00, 8'h00, "R2 R1 midnight rollover");
    expect_dig(7, 6, "R2 day advance"); expect_dig(6, 6, "R4 weekday advance");

    set_time(8'h23, 8'h59, 8'h59); to_second();
    expect_dig(6, 0, "R4 weekday wrap 6 to 0");
    wr_dig(6, 7); set_time(8'h23, 8'h59, 8'h59); to_second();
    expect_dig(6, 0, "R4 weekday 7 recovers");

    roll_date(8'h30, 8'h04, 8'h21, 8'h01, 8'h05, 8'h21, "R5 30-day month");
    roll_date(8'h30, 8'h05, 8'h21, 8'h31, 8'h05, 8'h21, "R5 31-day month");
    roll_date(8'h28, 8'h02, 8'h23, 8'h01, 8'h03, 8'h23, "R5 common Feb");
    roll_date(8'h28, 8'h02, 8'h24, 8'h29, 8'h02, 8'h24, "R5 leap Feb 24");
    roll_date(8'h29, 8'h02, 8'h24, 8'h01, 8'h03, 8'h24, "R5 leap Feb end");
    roll_date(8'h28, 8'h02, 8'h00, 8'h29, 8'h02, 8'h00, "R5 leap year 00");
    roll_date(8'h28, 8'h02, 8'h12, 8'h29, 8'h02, 8'h12, "R5 leap year 12");
    roll_date(8'h31, 8'h12, 8'h99, 8'h01, 8'h01, 8'h00, "R6 year wrap");

    set_time(8'h10, 8'h09, 8'h59); to_second();
    exp_time(8'h10, 8'h10, 8'h00, "R1 minute carry");

    mode24 = 0;
    set_time(8'h11, 8'h59, 8'h59); to_second();
    exp_time(8'h32, 8'h00, 8'h00, "R3 AM11 to PM12");
    set_date(8'h10, 8'h03, 8'h22);
    set_time(8'h31, 8'h59, 8'h59); to_second();
    exp_time(8'h12, 8'h00, 8'h00, "R3 PM11 to AM12");
    expect_dig(7, 1, "R3 day advance at midnight"); expect_dig(8, 1, "R3 day advance at midnight");
    set_time(8'h12, 8'h59, 8'h59); to_second();
    exp_time(8'h01, 8'h00, 8'h00, "R3 AM12 to AM1 no day");
    expect_dig(7, 1, "R3 no day advance at 1");
    mode24 = 1;

    set_time(8'h08, 8'h00, 8'h10);
    @(negedge clk) run = 0;
    to_second(); to_second();
    expect_dig(0, 0, "R7 held ones"); expect_dig(1, 1, "R7 held tens");
    chk_busy(0, "R10 no busy while held");
    @(negedge clk) run = 1;
    @(negedge clk);
    chk_busy(1, "R10 busy on release");
    expect_dig(0, 1, "R7 one advance on release");
    repeat (5) @(negedge clk);
    expect_dig(0, 1, "R7 exactly one advance"); expect_dig(1, 1, "R7 exactly one advance");

    set_time(8'h08, 8'h14, 8'h29); adjust(); tcount = 0;
    chk_busy(1, "R10 busy after adjust");
    exp_time(8'h08, 8'h14, 8'h00, "R8 round down");
    tick(); tick(); tick(); chk_busy(1, "R10 adjust busy 3 ticks");
    tick(); chk_busy(0, "R10 adjust busy ends 4 ticks");
    set_time(8'h08, 8'h14, 8'h45); adjust(); tcount = 0;
    exp_time(8'h08, 8'h15, 8'h00, "R8 round up");
    to_second();
    expect_dig(0, 1, "R8 prescaler cleared");

    set_time(8'h08, 8'h20, 8'h45);
    @(negedge clk) run = 0;
    adjust();
    to_second();
    exp_time(8'h08, 8'h20, 8'h45, "R9 adjust waits for run");
    @(negedge clk) run = 1;
    @(negedge clk); tcount = 0;
    exp_time(8'h08, 8'h21, 8'h00, "R9 adjust on release");
    repeat (4) @(negedge clk);
    expect_dig(0, 0, "R9 coincident carry discarded");

    wr_dig(1, 7); wr_dig(0, 15); to_second();
    exp_time(8'h08, 8'h22, 8'h00, "R11 illegal seconds recover");
    while (tcount != 15) tick();
    @(negedge clk); tick32k = 1; drv_addr = 2; wdata = 7; wr = 1;
    @(negedge clk); tick32k = 0; wr = 0; tcount = 0;
    @(negedge clk);
    expect_dig(2, 7, "R11 write wins its digit");
    expect_dig(0, 1, "R11 carry deferred not lost");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule